// File: doc/BRIEF.md
# Circular Capture DMA Writer

This block takes 32-bit samples from an internal monitor bus, buffers them in a small FIFO and stores them in system memory through a simple single-beat write master. Software programs a word-aligned start address and a word count, then sets the enable bit in the control register. Each sample that arrives while capture is enabled goes into the FIFO. The master drains the FIFO one word at a time, writing to consecutive word addresses.

Two modes are available. In one-shot mode the enable bit clears itself once the programmed number of words has been captured. In circular mode capture runs until software clears the enable bit, and the write address wraps over a window of length+1 words that begins at the start address. A read-only active flag stays high until capture has stopped and the FIFO has drained to memory. A sticky flag records any sample lost because the FIFO was full. A control bit can hold the bus request high for the whole active period.

Top module: `cap_dma_top`

## Requirements
- R1: After reset every register reads 0. Register byte offsets are control 0x00, start address 0x04, length 0x08, status 0x0C, current address 0x10 and remaining length 0x14. The start address keeps bits [31:2] only, so bits [1:0] read 0. The length keeps bits [16:0] only. Writes to 0x10 and 0x14 have no effect. Register reads return data one cycle after the address is presented.
- R2: Control bit 0 is enable, bit 1 is circular mode and bit 2 is force-request. Writing enable 1 while the block is idle does four things: the current address becomes the start address, the remaining length becomes the length value, the capture count is cleared and status bit 0 (active) goes to 1. A write of enable 1 while the block is still draining is ignored, and enable reads 0.
- R3: In one-shot mode exactly length+1 samples are accepted. Enable then clears itself, and later samples are not written to memory.
- R4: The k-th memory write goes to start+4k and carries the k-th accepted sample.
- R5: In circular mode enable stays 1. After the write at start+4*length, the next write goes back to the start address, so write k goes to start+4*(k mod (length+1)).
- R6: The current address register reads the byte address of the next write. The remaining length register reads the words left in the window minus one. In one-shot mode both registers read start+4*(length+1) and 0 once all words are written. In circular mode, after n writes they read start+4*(n mod (length+1)) and length-(n mod (length+1)).
- R7: Active stays 1 while buffered words remain, even after enable has cleared. Active falls to 0 only once enable is 0, the FIFO is empty and no transfer is in progress.
- R8: A sample that arrives while enabled with the FIFO full (default depth 8) is dropped, and status bit 1 (overflow) is set and stays set.
- R9: Writing status with bit 1 set clears the overflow flag. Writing status with bit 1 clear leaves it unchanged.
- R10: Each transfer has an address phase (bus_aphase high with bus_addr), held while bus_ready is low, followed by a data phase with bus_wdata, also held while bus_ready is low. No two address phases come back to back.
- R11: bus_req is high during every transfer. With force-request set, bus_req stays high for the whole time active is 1. While inactive, bus_req is 0.
- R12: Samples that arrive while enable is 0 are ignored. Clearing enable in software stops capture, and words already buffered are still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| smp_valid | input | 1 | Sample strobe from the monitor bus |
| smp_data | input | 32 | Sample word |
| bus_req | output | 1 | Bus request |
| bus_aphase | output | 1 | Address phase valid |
| bus_addr | output | 32 | Word-aligned write address |
| bus_wdata | output | 32 | Write data during the data phase |
| bus_ready | input | 1 | Phase completes when high |

## Verification
The hardest state to reach is a full FIFO that is still receiving samples, with a transfer stuck in its address phase. To get there, the bench holds bus_ready low while it feeds more samples than the FIFO holds, then releases the bus and checks that only the first eight samples reach memory, in order. A similar stall holds words in the FIFO after one-shot enable has cleared itself, which shows active outliving enable and a rejected restart. Sweeps over small lengths, with steady and stuttering ready patterns, check every write address and data word against arithmetic, including the circular wrap and the reload of the counters.

// File: rtl/capd_pkg.sv
package capd_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_DATA = 2'd2
  } bus_state_t;

  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_BASE = 5'h04;
  localparam logic [4:0] OFS_LEN  = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h0C;
  localparam logic [4:0] OFS_CUR  = 5'h10;
  localparam logic [4:0] OFS_REM  = 5'h14;

  localparam int CTL_EN    = 0;
  localparam int CTL_CIRC  = 1;
  localparam int CTL_FORCE = 2;
  localparam int ST_ACT    = 0;
  localparam int ST_OVF    = 1;
endpackage

// File: rtl/capd_fifo.sv
module capd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/capd_capture.sv
module capd_capture #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             circ,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             smp_valid,
  input  logic             full,
  output logic             push,
  output logic             ovf_set,
  output logic             done
);
  logic [LEN_W-1:0] cnt_q;

  assign push    = smp_valid & en & ~full;
  assign ovf_set = smp_valid & en & full;
  // last word of a one-shot capture
  assign done    = push & ~circ & (cnt_q == len);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (push && !circ) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/capd_writer.sv
module capd_writer
  import capd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW_W   = 30,
  parameter int LEN_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW_W-1:0]   base,
  input  logic [LEN_W-1:0]  len,
  input  logic              circ,
  input  logic              force_req,
  input  logic              en,
  input  logic              empty,
  input  logic [DATA_W-1:0] head,
  input  logic              bus_ready,
  output logic              pop,
  output logic              bus_aphase,
  output logic              bus_req,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [AW_W-1:0]   cur,
  output logic [LEN_W-1:0]  rem,
  output logic              active
);
  bus_state_t state_q;
  logic       xfer_done;

  assign xfer_done = (state_q == BUS_DATA) && bus_ready;
  assign pop       = xfer_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= BUS_IDLE;
      bus_wdata <= '0;
    end else begin
      case (state_q)
        BUS_IDLE: if (!empty) state_q <= BUS_ADDR;
        BUS_ADDR: if (bus_ready) begin
          state_q   <= BUS_DATA;
          bus_wdata <= head;
        end
        BUS_DATA: if (bus_ready) state_q <= BUS_IDLE;
        default:  state_q <= BUS_IDLE;
      endcase
    end
  end

  // address and remaining-length counters
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      rem <= '0;
    end else if (start) begin
      cur <= base;
      rem <= len;
    end else if (xfer_done) begin
      if (rem == '0 && circ) begin
        cur <= base;
        rem <= len;
      end else begin
        cur <= cur + 1'b1;
        if (rem != '0) rem <= rem - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
    end else if (!en && empty && state_q == BUS_IDLE) begin
      active <= 1'b0;
    end
  end

  assign bus_aphase = (state_q == BUS_ADDR);
  assign bus_req    = (state_q != BUS_IDLE) | (force_req & active);
endmodule

// File: rtl/capd_regs.sv
module capd_regs
  import capd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17,
  parameter int AW_W   = ADDR_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             auto_clr,
  input  logic             ovf_set,
  input  logic             active,
  input  logic [AW_W-1:0]  cur,
  input  logic [LEN_W-1:0] rem,
  output logic             en_q,
  output logic             circ_q,
  output logic             force_q,
  output logic [AW_W-1:0]  base_q,
  output logic [LEN_W-1:0] len_q,
  output logic             ovf_q,
  output logic             start,
  output logic [31:0]      reg_rdata
);
  logic wr_ctrl, wr_base, wr_len, wr_stat;

  assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  assign wr_base = reg_we && (reg_addr == OFS_BASE);
  assign wr_len  = reg_we && (reg_addr == OFS_LEN);
  assign wr_stat = reg_we && (reg_addr == OFS_STAT);

  // a new run only begins from a fully idle block
  assign start = wr_ctrl & reg_wdata[CTL_EN] & ~en_q & ~active;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      circ_q  <= 1'b0;
      force_q <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= reg_wdata[CTL_EN] & (en_q | ~active);
        circ_q  <= reg_wdata[CTL_CIRC];
        force_q <= reg_wdata[CTL_FORCE];
      end else if (auto_clr) begin
        en_q <= 1'b0;
      end
      if (wr_base) base_q <= reg_wdata[ADDR_W-1:2];
      if (wr_len)  len_q  <= reg_wdata[LEN_W-1:0];
      if (ovf_set) ovf_q <= 1'b1;
      else if (wr_stat && reg_wdata[ST_OVF]) ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        OFS_CTRL: reg_rdata <= {29'd0, force_q, circ_q, en_q};
        OFS_BASE: reg_rdata <= 32'({base_q, 2'b00});
        OFS_LEN:  reg_rdata <= 32'(len_q);
        OFS_STAT: reg_rdata <= {30'd0, ovf_q, active};
        OFS_CUR:  reg_rdata <= 32'({cur, 2'b00});
        OFS_REM:  reg_rdata <= 32'(rem);
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cap_dma_top.sv
module cap_dma_top #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 17,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              bus_req,
  output logic              bus_aphase,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready
);
  localparam int AW_W = ADDR_W - 2;

  logic              en_w, circ_w, force_w, ovf_w, start_w, act_w;
  logic [AW_W-1:0]   base_w, cur_w;
  logic [LEN_W-1:0]  len_w, rem_w;
  logic              push_w, pop_w, full_w, empty_w, ovf_set_w, done_w;
  logic [DATA_W-1:0] head_w;

  capd_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .AW_W(AW_W)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .auto_clr(done_w), .ovf_set(ovf_set_w),
    .active(act_w), .cur(cur_w), .rem(rem_w), .en_q(en_w), .circ_q(circ_w),
    .force_q(force_w), .base_q(base_w), .len_q(len_w), .ovf_q(ovf_w),
    .start(start_w), .reg_rdata(reg_rdata)
  );

  capd_capture #(.LEN_W(LEN_W)) cap_i (
    .clk(clk), .rst(rst), .en(en_w), .circ(circ_w), .start(start_w),
    .len(len_w), .smp_valid(smp_valid), .full(full_w), .push(push_w),
    .ovf_set(ovf_set_w), .done(done_w)
  );

  capd_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(push_w), .pop(pop_w), .din(smp_data),
    .dout(head_w), .full(full_w), .empty(empty_w)
  );

  capd_writer #(.DATA_W(DATA_W), .AW_W(AW_W), .LEN_W(LEN_W)) wr_i (
    .clk(clk), .rst(rst), .start(start_w), .base(base_w), .len(len_w),
    .circ(circ_w), .force_req(force_w), .en(en_w), .empty(empty_w),
    .head(head_w), .bus_ready(bus_ready), .pop(pop_w),
    .bus_aphase(bus_aphase), .bus_req(bus_req), .bus_wdata(bus_wdata),
    .cur(cur_w), .rem(rem_w), .active(act_w)
  );

  assign bus_addr = {cur_w, 2'b00};
endmodule

// File: rtl/capd_checker.sv
module capd_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [4:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              bus_req,
  input logic              bus_aphase,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ready,
  input logic              active,
  input logic              ovf
);
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    bus_aphase && !bus_ready |=> bus_aphase && $stable(bus_addr));

  a_r10_single_addr: assert property (@(posedge clk) disable iff (rst)
    bus_aphase && bus_ready |=> !bus_aphase);

  a_r7_busy_means_active: assert property (@(posedge clk) disable iff (rst)
    bus_aphase |-> active);

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !active |-> !bus_req);

  a_r8_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
    ovf && !(reg_we && reg_addr == 5'h0C && reg_wdata[1]) |=> ovf);
endmodule

bind cap_dma_top capd_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .bus_req(bus_req), .bus_aphase(bus_aphase),
  .bus_addr(bus_addr), .bus_ready(bus_ready), .active(act_w), .ovf(ovf_w)
);

// File: tb/cap_dma_top_tb.sv
module cap_dma_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        smp_valid;
  logic [31:0] smp_data;
  logic        bus_req, bus_aphase, bus_ready;
  logic [31:0] bus_addr, bus_wdata;

  cap_dma_top dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .bus_req(bus_req), .bus_aphase(bus_aphase),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready)
  );

  always #2 clk = ~clk;

  int          n_chk = 0, n_fail = 0, cyc = 0;
  int          wr_k = 0, exp_len = 0, rdy_mode = 0, scnt = 0;
  logic [31:0] exp_base = 0, pat = 0, dph_addr = 0;
  logic        dph = 1'b0, fin = 1'b0;
  string       wtag = "R4";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ready generator, write monitor and watchdog
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0:       bus_ready = 1'b1;
      1:       bus_ready = (cyc % 3) != 0;
      default: bus_ready = 1'b0;
    endcase
    if (rst) begin
      dph = 1'b0;
    end else if (dph && bus_ready) begin
      check({wtag, " write address"}, dph_addr, exp_base + 32'(4 * (wr_k % (exp_len + 1))));
      check({wtag, " write data"}, bus_wdata, pat + 32'(wr_k));
      wr_k++;
      dph = 1'b0;
    end else if (bus_aphase && bus_ready) begin
      dph = 1'b1;
      dph_addr = bus_addr;
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic regw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic regr(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic feed(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_data = pat + 32'(scnt); scnt++;
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (gap - 2) @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 500; i++) begin
      regr(5'h0C, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic setup(input logic [31:0] base, input int len, input string tag);
    regw(5'h04, base);
    regw(5'h08, 32'(len));
    exp_base = base; exp_len = len; wr_k = 0; scnt = 0;
    pat = 32'hC0DE_0000 + (base >> 4);
    wtag = tag;
  endtask

  initial begin
    logic [31:0] v;
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    smp_valid = 1'b0; smp_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state and register map
    for (int a = 0; a < 6; a++) begin
      regr(5'(a * 4), v);
      check("R1 reset register", v, 32'd0);
    end
    check("R1 reset bus_req", {31'd0, bus_req}, 32'd0);
    check("R1 reset bus_aphase", {31'd0, bus_aphase}, 32'd0);
    regw(5'h04, 32'hFFFF_FFFF); regr(5'h04, v);
    check("R1 start address low bits", v, 32'hFFFF_FFFC);
    regw(5'h08, 32'hFFFF_FFFF); regr(5'h08, v);
    check("R1 length width", v, 32'h0001_FFFF);
    regw(5'h10, 32'h5555_5555); regr(5'h10, v);
    check("R1 current address read-only", v, 32'd0);
    regw(5'h14, 32'h5555_5555); regr(5'h14, v);
    check("R1 remaining read-only", v, 32'd0);

    // R12 samples while disabled are ignored
    wr_k = 0;
    feed(4, 3);
    repeat (20) @(negedge clk);
    check("R12 disabled samples ignored", 32'(wr_k), 32'd0);

    // R2 R3 R4 R6 one-shot sweep over lengths and ready patterns
    for (int m = 0; m < 2; m++) begin
      for (int len = 0; len < 6; len++) begin
        rdy_mode = m;
        setup(32'h1000_0000 + 32'(len * 256 + m * 4096), len, "R4");
        regw(5'h00, 32'h1);
        regr(5'h10, v); check("R2 current address loaded", v, exp_base);
        regr(5'h14, v); check("R2 remaining loaded", v, 32'(len));
        regr(5'h0C, v); check("R2 active set", v, 32'h1);
        feed(len + 3, 8);
        wait_idle();
        check("R3 one-shot word count", 32'(wr_k), 32'(len + 1));
        regr(5'h00, v); check("R3 enable self-cleared", v, 32'h0);
        regr(5'h10, v); check("R6 final current address", v, exp_base + 32'(4 * (len + 1)));
        regr(5'h14, v); check("R6 final remaining", v, 32'h0);
        regr(5'h0C, v); check("R7 inactive after drain", v, 32'h0);
      end
    end

    // R7 active outlives enable; restart while draining rejected (R2)
    rdy_mode = 2;
    setup(32'h2000_0000, 1, "R4");
    regw(5'h00, 32'h1);
    feed(2, 4);
    repeat (10) @(negedge clk);
    regr(5'h00, v); check("R7 enable cleared while stalled", v, 32'h0);
    regr(5'h0C, v); check("R7 active while words buffered", v, 32'h1);
    check("R10 address phase held under stall", {31'd0, bus_aphase}, 32'h1);
    regw(5'h00, 32'h1);
    regr(5'h00, v); check("R2 restart while draining ignored", v, 32'h0);
    rdy_mode = 0;
    wait_idle();
    check("R7 drained word count", 32'(wr_k), 32'd2);

    // R5 R6 circular wrap
    rdy_mode = 1;
    setup(32'h3000_0100, 2, "R5");
    regw(5'h00, 32'h3);
    feed(8, 8);
    repeat (30) @(negedge clk);
    regr(5'h00, v); check("R5 enable stays in circular mode", v, 32'h3);
    regr(5'h10, v); check("R6 circular current address", v, exp_base + 32'd8);
    regr(5'h14, v); check("R6 circular remaining", v, 32'd0);
    feed(1, 8);
    repeat (30) @(negedge clk);
    regr(5'h10, v); check("R5 address reload at wrap", v, exp_base);
    regr(5'h14, v); check("R5 remaining reload at wrap", v, 32'd2);
    regw(5'h00, 32'h0);
    wait_idle();
    check("R5 circular word count", 32'(wr_k), 32'd9);

    // R8 R9 overflow while bus stalled
    rdy_mode = 2;
    setup(32'h4000_0000, 100, "R8");
    regw(5'h00, 32'h1);
    feed(11, 2);
    regr(5'h0C, v); check("R8 overflow flag set", v, 32'h3);
    rdy_mode = 0;
    repeat (60) @(negedge clk);
    check("R8 dropped samples not written", 32'(wr_k), 32'd8);
    regw(5'h0C, 32'h0);
    regr(5'h0C, v); check("R9 write 0 keeps overflow", v[1:0], 32'h3);
    regw(5'h0C, 32'h2);
    regr(5'h0C, v); check("R9 write 1 clears overflow", v[1:0], 32'h1);
    regw(5'h00, 32'h0);
    wait_idle();

    // R11 bus request with and without force
    setup(32'h5000_0000, 4, "R4");
    regw(5'h00, 32'h1);
    repeat (3) @(negedge clk);
    check("R11 no request when idle without force", {31'd0, bus_req}, 32'h0);
    regw(5'h00, 32'h0);
    wait_idle();
    regw(5'h00, 32'h5);
    repeat (3) @(negedge clk);
    check("R11 forced request while active", {31'd0, bus_req}, 32'h1);
    regw(5'h00, 32'h0);
    wait_idle();
    check("R11 request released when inactive", {31'd0, bus_req}, 32'h0);

    // R12 software clear stops a one-shot run early
    setup(32'h6000_0000, 10, "R12");
    regw(5'h00, 32'h1);
    feed(3, 8);
    repeat (20) @(negedge clk);
    regw(5'h00, 32'h0);
    feed(3, 8);
    wait_idle();
    check("R12 capture stops on software clear", 32'(wr_k), 32'd3);

    finish_run();
  end
endmodule